// File: doc/BRIEF.md
# Two-Rail Power Sequencing Controller

This block orders the switch-on and switch-off of two supply rails: rail A, fed by a switching converter, and rail B, fed by a linear regulator. Three strap pins set the mode. One pin belongs to each rail and the third picks the shutdown order. Whichever rail pin is toggled acts as the single enable. The controller drives an enable line to each rail. It reads a power-good flag from each rail (set at 90% of target) and a soft-start-complete flag from rail A. It also drives a select line that chooses where rail B draws its input. A cycle counter scaled from a delay setting sets the spacing between the two rails.

In sequenced mode, only one rail pin carries the enable and the other stays low. The rail whose pin is high comes up first. The second rail follows once the first rail reports power-good and the programmed delay has run out. On shutdown the same delay separates the two disables. The order pin decides whether the first rail to come up is the first or the last to go down. When both rail pins are high, both rails switch together. A digital under-voltage gate with hysteresis holds both rails off while the supply level is too low. Strap pins pass through a two-flop synchronizer. The mode, the order and the delay setting are captured when a sequence leaves the all-off state.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, `rail_a_en`, `rail_b_en` and `b_src_main` are 0 and `seq_status` is 0 (off). Status codes: 0 off, 1 rising, 2 on, 3 falling.
- R2: While both rail pins are low, both enables stay 0 and status stays 0, whatever the order pin is.
- R3: With both rail pins high, both enables rise on the same edge. This is the third rising clock edge after the pins change, since two edges are spent in the synchronizer. Status then reads 2.
- R4: With one rail pin high, the rail tied to that pin is enabled on the third edge and status reads 1. The other rail stays off until the first rail's power-good is sampled high. It is then enabled D = `dly_set` × `UNIT_CYC` edges after that sampling edge, or on the same edge when D is 0.
- R5: When the enable pin drops after a sequenced power-up, status reads 3. Order pin 0 disables the first-on rail first; order pin 1 disables it last. The second disable follows D edges after the first, and status then returns to 0. With D = 0 both rails drop on the same edge.
- R6: In simultaneous mode, lowering the pins disables both rails on the same edge and status returns to 0.
- R7: If the enable pin drops before the second rail is enabled, the first rail is disabled, the second rail is never enabled, and status returns to 0.
- R8: Once a sequence has started, changes to the other rail pin, the order pin or `dly_set` have no effect on enables, delay length or shutdown order until status is back at 0.
- R9: `b_src_main` is 1 (rail B input taken from rail A's output) one edge after the edge at which `rail_a_en` and `ss_done_a` are both sampled high. It is 0 (raw supply) otherwise, including while rail A is off.
- R10: Rails run only while the supply gate is open. The gate opens when `supply_lvl` ≥ `UV_ON` and closes only when `supply_lvl` < `UV_OFF`. Levels in between keep the gate's current state. A closed gate forces both enables to 0 and status to 0 within two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | Rail A strap / enable pin |
| pin_b | input | 1 | Rail B strap / enable pin |
| pin_order | input | 1 | Shutdown order: 0 first-on first-off, 1 first-on last-off |
| dly_set | input | DLY_W | Delay setting, scaled by UNIT_CYC |
| supply_lvl | input | LVL_W | Sampled supply level for the under-voltage gate |
| pg_a | input | 1 | Rail A power-good (at 90%) |
| pg_b | input | 1 | Rail B power-good (at 90%) |
| ss_done_a | input | 1 | Rail A soft start complete |
| rail_a_en | output | 1 | Rail A enable |
| rail_b_en | output | 1 | Rail B enable |
| b_src_main | output | 1 | Rail B input select: 1 rail A output, 0 raw supply |
| seq_status | output | 2 | Sequencer status: 0 off, 1 rising, 2 on, 3 falling |

## Verification
The assertions check these properties on every cycle:
- status and enable pattern agree: no enable while off, exactly one rail during rising and falling, both rails while on;
- the source select never claims rail A's output unless rail A was enabled and soft-started;
- a closed supply gate clears both enables;
- the gate's hysteresis behaves as specified.

Other behaviour is visible only in the bench scenarios:
- the exact number of edges between power-good and the second enable;
- which rail drops first for each order setting;
- aborts at each stage of power-up;
- that strap changes made mid-sequence are ignored.

// File: rtl/rseq_pkg.sv
`timescale 1ns/1ps
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_PG,
    ST_UP_DLY,
    ST_ON,
    ST_DN_DLY
  } seq_st_t;

  typedef enum logic [1:0] {
    M_SIM,
    M_A_FIRST,
    M_B_FIRST
  } seq_mode_t;

  localparam logic [1:0] STAT_OFF  = 2'd0;
  localparam logic [1:0] STAT_RISE = 2'd1;
  localparam logic [1:0] STAT_ON   = 2'd2;
  localparam logic [1:0] STAT_FALL = 2'd3;

  function automatic logic [1:0] status_code(seq_st_t s);
    case (s)
      ST_WAIT_PG, ST_UP_DLY: status_code = STAT_RISE;
      ST_ON:                 status_code = STAT_ON;
      ST_DN_DLY:             status_code = STAT_FALL;
      default:               status_code = STAT_OFF;
    endcase
  endfunction

  // Rail to drop first on shutdown: first-on rail when order is 0, the other when 1.
  function automatic logic drop_a_first(seq_mode_t m, logic order_last);
    drop_a_first = (m == M_A_FIRST) ^ order_last;
  endfunction

endpackage

// File: rtl/rseq_sync.sv
`timescale 1ns/1ps
module rseq_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  genvar i;
  for (i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= din[i];
        st2 <= st1;
      end
    end
    assign dout[i] = st2;
  end

endmodule

// File: rtl/rseq_uvlo.sv
`timescale 1ns/1ps
module rseq_uvlo #(
  parameter int LVL_W   = 8,
  parameter int ON_LVL  = 200,
  parameter int OFF_LVL = 190
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  output logic             ok
);

  localparam logic [LVL_W-1:0] ON_L  = LVL_W'(ON_LVL);
  localparam logic [LVL_W-1:0] OFF_L = LVL_W'(OFF_LVL);

  function automatic logic gate_next(logic cur, logic [LVL_W-1:0] v);
    if (cur) gate_next = (v >= OFF_L);
    else     gate_next = (v >= ON_L);
  endfunction

  logic ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= gate_next(ok_q, lvl);
  end
  assign ok = ok_q;

  // R10: inside the hysteresis band an open gate stays open
  a_r10_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && lvl >= OFF_L) |=> ok_q);
  // R10: below the lower threshold the gate closes on the next edge
  a_r10_trip_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl < OFF_L) |=> !ok_q);
  // R10: a closed gate opens only at or above the upper threshold
  a_r10_open_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> ($past(lvl) >= ON_L));

endmodule

// File: rtl/rseq_timer.sv
`timescale 1ns/1ps
module rseq_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (dec && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl
  import rseq_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int UV_ON    = 200,
  parameter int UV_OFF   = 190,
  parameter int DLY_W    = 4,
  parameter int UNIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_order,
  input  logic [DLY_W-1:0] dly_set,
  input  logic [LVL_W-1:0] supply_lvl,
  input  logic             pg_a,
  input  logic             pg_b,
  input  logic             ss_done_a,
  output logic             rail_a_en,
  output logic             rail_b_en,
  output logic             b_src_main,
  output logic [1:0]       seq_status
);

  localparam int CNT_W = DLY_W + $clog2(UNIT_CYC + 1);

  function automatic logic [CNT_W-1:0] delay_len(logic [DLY_W-1:0] s);
    delay_len = CNT_W'(s) * CNT_W'(UNIT_CYC);
  endfunction

  // ---- synchronized straps and supply gate ----
  logic [2:0] straps_s;
  logic s_a, s_b, s_ord, uv_ok;

  rseq_sync #(.W(3)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({pin_order, pin_b, pin_a}),
    .dout(straps_s)
  );
  assign s_a   = straps_s[0];
  assign s_b   = straps_s[1];
  assign s_ord = straps_s[2];

  rseq_uvlo #(.LVL_W(LVL_W), .ON_LVL(UV_ON), .OFF_LVL(UV_OFF)) u_uvlo (
    .clk (clk), .rst_n (rst_n), .lvl (supply_lvl), .ok (uv_ok)
  );

  // ---- state ----
  seq_st_t          st_q, st_n;
  seq_mode_t        mode_q, mode_n;
  logic             ord_q, ord_n;
  logic [CNT_W-1:0] dly_q, dly_n;
  logic             en_a_q, en_a_n, en_b_q, en_b_n, src_q;

  // ---- named events ----
  logic start_req, req_live, pg_first, drop_a;
  logic t_load, t_dec, t_last;

  assign start_req = s_a | s_b;
  assign req_live  = (mode_q == M_SIM)     ? (s_a & s_b) :
                     (mode_q == M_A_FIRST) ? s_a : s_b;
  assign pg_first  = (mode_q == M_A_FIRST) ? pg_a : pg_b;
  assign drop_a    = drop_a_first(mode_q, ord_q);

  rseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk), .rst_n (rst_n),
    .load (t_load), .load_val (dly_q), .dec (t_dec), .last (t_last)
  );

  always_comb begin
    st_n   = st_q;
    mode_n = mode_q;
    ord_n  = ord_q;
    dly_n  = dly_q;
    en_a_n = en_a_q;
    en_b_n = en_b_q;
    t_load = 1'b0;
    t_dec  = 1'b0;
    case (st_q)
      ST_OFF: begin
        if (start_req && uv_ok) begin
          ord_n = s_ord;
          dly_n = delay_len(dly_set);
          if (s_a && s_b) begin
            mode_n = M_SIM;
            en_a_n = 1'b1;
            en_b_n = 1'b1;
            st_n   = ST_ON;
          end else begin
            mode_n = s_a ? M_A_FIRST : M_B_FIRST;
            en_a_n = s_a;
            en_b_n = s_b;
            st_n   = ST_WAIT_PG;
          end
        end
      end
      ST_WAIT_PG: begin
        if (!req_live) begin
          en_a_n = 1'b0;
          en_b_n = 1'b0;
          st_n   = ST_OFF;
        end else if (pg_first) begin
          if (dly_q == '0) begin
            en_a_n = 1'b1;
            en_b_n = 1'b1;
            st_n   = ST_ON;
          end else begin
            t_load = 1'b1;
            st_n   = ST_UP_DLY;
          end
        end
      end
      ST_UP_DLY: begin
        if (!req_live) begin
          en_a_n = 1'b0;
          en_b_n = 1'b0;
          st_n   = ST_OFF;
        end else if (t_last) begin
          en_a_n = 1'b1;
          en_b_n = 1'b1;
          st_n   = ST_ON;
        end else begin
          t_dec = 1'b1;
        end
      end
      ST_ON: begin
        if (!req_live) begin
          if (mode_q == M_SIM || dly_q == '0) begin
            en_a_n = 1'b0;
            en_b_n = 1'b0;
            st_n   = ST_OFF;
          end else begin
            en_a_n = !drop_a;
            en_b_n = drop_a;
            t_load = 1'b1;
            st_n   = ST_DN_DLY;
          end
        end
      end
      ST_DN_DLY: begin
        if (t_last) begin
          en_a_n = 1'b0;
          en_b_n = 1'b0;
          st_n   = ST_OFF;
        end else begin
          t_dec = 1'b1;
        end
      end
      default: begin
        en_a_n = 1'b0;
        en_b_n = 1'b0;
        st_n   = ST_OFF;
      end
    endcase
    if (!uv_ok) begin
      en_a_n = 1'b0;
      en_b_n = 1'b0;
      st_n   = ST_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      mode_q <= M_SIM;
      ord_q  <= 1'b0;
      dly_q  <= '0;
      en_a_q <= 1'b0;
      en_b_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
      ord_q  <= ord_n;
      dly_q  <= dly_n;
      en_a_q <= en_a_n;
      en_b_q <= en_b_n;
      src_q  <= en_a_q & ss_done_a;
    end
  end

  assign rail_a_en  = en_a_q;
  assign rail_b_en  = en_b_q;
  assign b_src_main = src_q;
  assign seq_status = status_code(st_q);

  // ---- assertions ----
  // R1, R2: the off status never coexists with an enabled rail
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_status == STAT_OFF) |-> (!rail_a_en && !rail_b_en));
  // R4: during power-up exactly one rail is enabled
  a_r4_one_rising: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_status == STAT_RISE) |-> $onehot({rail_a_en, rail_b_en}));
  // R3: on status means both rails are enabled
  a_r3_on_both: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_status == STAT_ON) |-> (rail_a_en && rail_b_en));
  // R5: during power-down exactly one rail remains
  a_r5_one_falling: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_status == STAT_FALL) |-> $onehot({rail_a_en, rail_b_en}));
  // R9: rail B takes rail A's output only after A was on and soft-started
  a_r9_src_after_ss: assert property (@(posedge clk) disable iff (!rst_n)
    b_src_main |-> $past(rail_a_en && ss_done_a));
  // R10: a closed supply gate clears both enables on the next edge
  a_r10_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> (!rail_a_en && !rail_b_en));

endmodule

// File: tb/sim_rail_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rail_seq_ctrl;

  localparam int UNIT = 4;
  localparam int UVON = 200;
  localparam int UVOFF = 190;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 0, pin_b = 0, pin_ord = 0;
  logic [3:0] dset = 4'd0;
  logic [7:0] lvl = 8'd0;
  logic pg_a = 0, pg_b = 0, ss = 0;
  logic en_a, en_b, src;
  logic [1:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rail_seq_ctrl u0 (
    .clk (clk), .rst_n (rst_n),
    .pin_a (pin_a), .pin_b (pin_b), .pin_order (pin_ord),
    .dly_set (dset), .supply_lvl (lvl),
    .pg_a (pg_a), .pg_b (pg_b), .ss_done_a (ss),
    .rail_a_en (en_a), .rail_b_en (en_b),
    .b_src_main (src), .seq_status (status)
  );

  // {pin_a, pin_b, order, dly_set}
  localparam logic [6:0] VEC [0:5] = '{
    {1'b1, 1'b0, 1'b0, 4'd2},
    {1'b1, 1'b0, 1'b1, 4'd1},
    {1'b0, 1'b1, 1'b0, 4'd3},
    {1'b0, 1'b1, 1'b1, 4'd0},
    {1'b1, 1'b0, 1'b1, 4'd5},
    {1'b0, 1'b1, 1'b0, 4'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Edges until the given condition; sampled at negedge after each posedge.
  task automatic edges_until_b(input logic want, output int k);
    k = 0;
    do begin
      @(posedge clk); k++; @(negedge clk);
    end while (en_b != want && k < 300);
  endtask

  task automatic edges_until_a(input logic want, output int k);
    k = 0;
    do begin
      @(posedge clk); k++; @(negedge clk);
    end while (en_a != want && k < 300);
  endtask

  task automatic run_seq(input logic a, input logic b, input logic ord, input logic [3:0] ds);
    int d;
    int k;
    d = int'(ds) * UNIT;
    @(negedge clk);
    pin_a = a; pin_b = b; pin_ord = ord; dset = ds;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 first rail enabled", a ? en_a : en_b, 1);
    chk("R4 second rail off", a ? en_b : en_a, 0);
    chk("R4 status rising", status, 1);
    cyc(3);
    chk("R4 second waits for power-good", a ? en_b : en_a, 0);
    if (a) pg_a = 1; else pg_b = 1;
    if (a) edges_until_b(1'b1, k); else edges_until_a(1'b1, k);
    chk("R4 delay after power-good", k, d + 1);
    chk("R4 status on", status, 2);
    if (a) pg_b = 1; else pg_a = 1;
    cyc(2);
    if (a) pin_a = 0; else pin_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (d == 0) begin
      chk("R5 zero delay both off A", en_a, 0);
      chk("R5 zero delay both off B", en_b, 0);
    end else begin
      // first-on rail still enabled only when order is first-on/last-off
      chk("R5 first-on rail after first disable", a ? en_a : en_b, ord ? 1 : 0);
      chk("R5 second rail after first disable", a ? en_b : en_a, ord ? 0 : 1);
      chk("R5 status falling", status, 3);
      if ((a && !ord) || (!a && ord)) edges_until_b(1'b0, k);
      else edges_until_a(1'b0, k);
      chk("R5 gap between disables", k, d);
    end
    chk("R5 status off at end", status, 0);
    pg_a = 0; pg_b = 0;
    cyc(4);
  endtask

  initial begin
    int k;
    int seen;
    // R1 reset state
    cyc(3);
    chk("R1 rail_a_en in reset", en_a, 0);
    chk("R1 rail_b_en in reset", en_b, 0);
    chk("R1 b_src_main in reset", src, 0);
    chk("R1 status in reset", status, 0);
    rst_n = 1;
    cyc(2);
    chk("R1 status after reset", status, 0);

    // R10 under-voltage lockout (supply low)
    pin_a = 1;
    cyc(6);
    chk("R10 locked out at zero supply", en_a, 0);
    lvl = 8'(UVON - 1);
    cyc(6);
    chk("R10 locked out just below on level", en_a, 0);
    lvl = 8'(UVON);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 rail A up two edges after gate opens", en_a, 1);
    lvl = 8'(UVOFF);
    cyc(5);
    chk("R10 hysteresis keeps rail A on", en_a, 1);
    lvl = 8'(UVOFF - 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 lockout drops rail A", en_a, 0);
    chk("R10 lockout status off", status, 0);
    lvl = 8'(UVOFF + 5);
    cyc(5);
    chk("R10 band does not reopen gate", en_a, 0);
    lvl = 8'd230;
    cyc(4);
    chk("R10 reopened gate restarts rail A", en_a, 1);
    pin_a = 0;
    cyc(6);
    chk("R7 drop before power-good ends rise", en_a, 0);

    // R2 all-off straps
    pin_ord = 1;
    cyc(8);
    chk("R2 both off A", en_a, 0);
    chk("R2 both off B", en_b, 0);
    chk("R2 status off", status, 0);

    // Vector table: sequenced power-up and power-down
    for (int i = 0; i < 6; i++) begin
      run_seq(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R3 / R6 simultaneous mode
    @(negedge clk);
    pin_a = 1; pin_b = 1; pin_ord = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet enabled after two edges", en_a | en_b, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 rail A on third edge", en_a, 1);
    chk("R3 rail B on third edge", en_b, 1);
    chk("R3 status on", status, 2);
    pin_a = 0; pin_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 rail A off together", en_a, 0);
    chk("R6 rail B off together", en_b, 0);
    chk("R6 status off", status, 0);
    cyc(4);

    // R7 abort during delay phase
    dset = 4'd15;
    pin_a = 1;
    cyc(4);
    pg_a = 1;
    seen = 0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (en_b) seen++;
    end
    pin_a = 0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (en_b) seen++;
    end
    chk("R7 second rail never enabled", seen, 0);
    chk("R7 first rail off after abort", en_a, 0);
    chk("R7 status off after abort", status, 0);
    pg_a = 0;
    cyc(4);

    // R8 strap changes mid-sequence ignored
    dset = 4'd2; pin_ord = 0;
    pin_a = 1;
    cyc(4);
    pin_b = 1; pin_ord = 1; dset = 4'd9;
    cyc(6);
    chk("R8 other pin does not enable rail B", en_b, 0);
    pg_a = 1;
    edges_until_b(1'b1, k);
    chk("R8 latched delay used", k, 2 * UNIT + 1);
    pg_b = 1;
    cyc(2);
    pin_a = 0; pin_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 latched order drops rail A first", en_a, 0);
    chk("R8 rail B still on", en_b, 1);
    edges_until_b(1'b0, k);
    chk("R8 latched delay on shutdown", k, 2 * UNIT);
    pg_a = 0; pg_b = 0;
    cyc(4);

    // R9 rail B input source select
    dset = 4'd1; pin_ord = 0;
    ss = 1;
    pin_b = 1;
    cyc(5);
    chk("R9 raw supply while rail A off", src, 0);
    pg_b = 1;
    edges_until_a(1'b1, k);
    chk("R9 still raw on edge rail A rises", src, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 moves to rail A output", src, 1);
    ss = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 back to raw without soft-start done", src, 0);
    pg_a = 1;
    pin_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 order 0 drops rail B first", en_b, 0);
    edges_until_a(1'b0, k);
    chk("R5 gap in rail B first mode", k, UNIT);
    pg_a = 0; pg_b = 0;
    cyc(3);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule